// File: doc/BRIEF.md
# Self-Framing Serial Register Writer

This block turns a one-wire serial register write into a parallel write request. It samples a single data line on the falling edge of a shared serial clock. It has no frame-sync input: the frame announces itself with a high start bit in the data stream. After the start bit come three bits that are discarded, then a 3-bit register address and an 8-bit value. Each of these two fields is sent most significant bit first.

When the last value bit has been sampled, the block raises a write strobe for one serial clock cycle. The address and value are presented beside the strobe for a downstream arbiter. The line may then carry the next start bit at once. A sender that works in 16-bit words sends a leading zero, which the idle port ignores. The second bit of the word then serves as the start bit. Because the frame is found in the data itself, a write may begin at any time.

Top module: `sfw_serial_writer`

## Requirements
- R1: A synchronous active-high reset, sampled on a falling serial clock edge, drives wr_stb, wr_addr and wr_data to zero. It returns the port to idle even in the middle of a frame, so the next frame that follows decodes correctly.
- R2: While idle, a low sdi keeps the port idle. A high sdi sampled on a falling edge is taken as the start bit. A 16-bit word with a leading zero is therefore accepted, with its second bit acting as the start bit.
- R3: The three bits after the start bit are discarded, whatever their values.
- R4: The next 11 sampled bits form the write. The first three are wr_addr[2:0], most significant bit first. The following eight are wr_data[7:0], most significant bit first.
- R5: wr_stb is high for exactly one serial clock cycle. It rises at the falling edge that samples the last data bit, with wr_addr and wr_data valid during that same cycle. Each frame gives exactly one strobe.
- R6: A new start bit sampled on the falling edge right after the last data bit begins the next frame.
- R7: High bits inside a frame, in the discarded bits or in the address or data fields, never restart frame detection.
- R8: wr_addr and wr_data keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; every sample and register update happens on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data line carrying start bit, discarded bits, address and data |
| wr_stb | output | 1 | One-cycle write strobe for the arbiter |
| wr_addr | output | 3 | Register address of the completed write |
| wr_data | output | 8 | Register value of the completed write |

## Verification
The hardest case to reach is a data line that stays high at every point where a wrong decoder could act. The stimulus sets every discarded bit and every address and data bit to one. In that frame, a decoder that re-armed start detection would lose alignment and produce extra strobes or shifted fields. A second hard case is a start bit on the very edge after a last data bit, while the strobe is still high. The back-to-back test drives it from the same point in time at which it checks that strobe. A reset in the middle of a frame, followed by a clean frame, shows that the frame counter really returns to idle.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    // Frame geometry
    localparam int SFW_ADDR_W    = 3;
    localparam int SFW_DATA_W    = 8;
    localparam int SFW_SKIP_BITS = 4;  // start bit plus discarded bits

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SKIP  = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;

    typedef struct packed {
        logic idle;
        logic shift_en;
        logic last;
    } ctrl_t;

    function automatic int cnt_width(input int skip_bits, input int field_bits);
        int top;
        top = (skip_bits > field_bits) ? skip_bits : field_bits;
        return (top < 2) ? 1 : $clog2(top);
    endfunction

endpackage

// File: rtl/sfw_frame_ctrl.sv
module sfw_frame_ctrl #(
    parameter int SKIP_BITS = sfw_pkg::SFW_SKIP_BITS,
    parameter int FIELD_W   = sfw_pkg::SFW_ADDR_W + sfw_pkg::SFW_DATA_W
) (
    input  logic           sclk,
    input  logic           rst,
    input  logic           sdi,
    output sfw_pkg::ctrl_t ctrl
);
    import sfw_pkg::*;

    localparam int              CNT_W      = cnt_width(SKIP_BITS, FIELD_W);
    localparam logic [CNT_W-1:0] SKIP_LAST  = CNT_W'(SKIP_BITS - 1);
    localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_W - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(negedge sclk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (sdi) begin
                        phase <= PH_SKIP;
                        cnt   <= CNT_W'(1);
                    end
                end
                PH_SKIP: begin
                    if (cnt == SKIP_LAST) begin
                        phase <= PH_SHIFT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (cnt == FIELD_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ctrl.idle     = (phase == PH_IDLE);
        ctrl.shift_en = (phase == PH_SHIFT);
        ctrl.last     = (phase == PH_SHIFT) && (cnt == FIELD_LAST);
    end

    // R2: a low line keeps an idle port idle
    p_idle_hold_r2: assert property (@(negedge sclk) disable iff (rst)
        (ctrl.idle && !sdi) |=> ctrl.idle);

    // R2: a high line at idle opens a frame
    p_start_open_r2: assert property (@(negedge sclk) disable iff (rst)
        (ctrl.idle && sdi) |=> !ctrl.idle);

    // R7: a frame in progress is never abandoned before its last bit
    p_no_retrigger_r7: assert property (@(negedge sclk) disable iff (rst)
        (!ctrl.idle && !ctrl.last) |=> !ctrl.idle);

    // R6: the port is idle right after the last field bit
    p_idle_after_last_r6: assert property (@(negedge sclk) disable iff (rst)
        ctrl.last |=> ctrl.idle);

endmodule

// File: rtl/sfw_shifter.sv
module sfw_shifter #(
    parameter int FIELD_W = sfw_pkg::SFW_ADDR_W + sfw_pkg::SFW_DATA_W
) (
    input  logic               sclk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               sdi,
    output logic [FIELD_W-1:0] field
);
    logic [FIELD_W-2:0] sr;

    always_ff @(negedge sclk) begin
        if (rst) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {sr[FIELD_W-3:0], sdi};
        end
    end

    // Word including the bit on the line at this edge
    assign field = {sr, sdi};

endmodule

// File: rtl/sfw_serial_writer.sv
module sfw_serial_writer #(
    parameter int ADDR_W    = sfw_pkg::SFW_ADDR_W,
    parameter int DATA_W    = sfw_pkg::SFW_DATA_W,
    parameter int SKIP_BITS = sfw_pkg::SFW_SKIP_BITS
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sdi,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    import sfw_pkg::*;

    localparam int FIELD_W = ADDR_W + DATA_W;

    ctrl_t              ctrl;
    logic [FIELD_W-1:0] field;

    sfw_frame_ctrl #(
        .SKIP_BITS (SKIP_BITS),
        .FIELD_W   (FIELD_W)
    ) u_ctrl (
        .sclk (sclk),
        .rst  (rst),
        .sdi  (sdi),
        .ctrl (ctrl)
    );

    sfw_shifter #(
        .FIELD_W (FIELD_W)
    ) u_shift (
        .sclk     (sclk),
        .rst      (rst),
        .shift_en (ctrl.shift_en),
        .sdi      (sdi),
        .field    (field)
    );

    always_ff @(negedge sclk) begin
        if (rst) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= ctrl.last;
            if (ctrl.last) begin
                wr_addr <= field[FIELD_W-1 -: ADDR_W];
                wr_data <= field[DATA_W-1:0];
            end
        end
    end

    // R5: the strobe never lasts two cycles
    p_strobe_pulse_r5: assert property (@(negedge sclk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8: outputs move only together with a strobe
    p_hold_between_r8: assert property (@(negedge sclk) disable iff (rst)
        ((wr_addr != $past(wr_addr)) || (wr_data != $past(wr_data))) |-> wr_stb);

endmodule

// File: tb/test_sfw_serial_writer.sv
module test_sfw_serial_writer;

    logic       sclk = 1'b0;
    logic       rst  = 1'b1;
    logic       sdi  = 1'b0;
    logic       wr_stb;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int stb_count = 0;

    always #4 sclk = ~sclk;  // 125 MHz

    sfw_serial_writer i_sfw_serial_writer (
        .sclk    (sclk),
        .rst     (rst),
        .sdi     (sdi),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always @(posedge sclk) begin
        if (!rst && wr_stb) stb_count <= stb_count + 1;
    end

    // All bench activity happens just after a rising edge, far from the sampling edge
    task automatic tick();
        @(posedge sclk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives start bit, discarded bits, address and data; returns at the point
    // where the strobe for the last bit is visible
    task automatic send_frame(input logic [2:0] dc, input logic [2:0] a, input logic [7:0] d);
        logic [14:0] bits;
        bits = {1'b1, dc, a, d};
        for (int i = 14; i >= 0; i--) begin
            sdi = bits[i];
            tick();
        end
    endtask

    task automatic expect_write(input string req, input logic [2:0] a, input logic [7:0] d);
        check({req, " strobe"}, int'(wr_stb), 1);
        check({req, " addr"}, int'(wr_addr), int'(a));
        check({req, " data"}, int'(wr_data), int'(d));
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R1 reset stb", int'(wr_stb), 0);
        check("R1 reset addr", int'(wr_addr), 0);
        check("R1 reset data", int'(wr_data), 0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_basic();
        int n0;
        n0 = stb_count;
        send_frame(3'b000, 3'b101, 8'hA6);
        expect_write("R4 basic", 3'b101, 8'hA6);
        sdi = 1'b0;
        tick();
        check("R5 strobe drops", int'(wr_stb), 0);
        check("R5 one strobe", stb_count - n0, 1);
        check("R8 addr held", int'(wr_addr), 3'b101);
        check("R8 data held", int'(wr_data), 8'hA6);
    endtask

    task automatic t_idle_low();
        int n0;
        n0 = stb_count;
        sdi = 1'b0;
        repeat (40) tick();
        check("R2 idle no strobe", stb_count - n0, 0);
        check("R8 idle addr held", int'(wr_addr), 3'b101);
        check("R8 idle data held", int'(wr_data), 8'hA6);
        send_frame(3'b010, 3'b011, 8'h3C);
        expect_write("R2 after idle", 3'b011, 8'h3C);
        sdi = 1'b0;
        tick();
    endtask

    task automatic t_all_ones();
        int n0;
        n0 = stb_count;
        send_frame(3'b111, 3'b111, 8'hFF);
        expect_write("R3 R7 ones", 3'b111, 8'hFF);
        sdi = 1'b0;
        repeat (20) tick();
        check("R7 single strobe", stb_count - n0, 1);
        send_frame(3'b101, 3'b001, 8'h81);
        expect_write("R3 dc ignored", 3'b001, 8'h81);
        sdi = 1'b0;
        tick();
    endtask

    task automatic t_back_to_back();
        int n0;
        n0 = stb_count;
        send_frame(3'b000, 3'b110, 8'h5A);
        expect_write("R6 first", 3'b110, 8'h5A);
        send_frame(3'b011, 3'b010, 8'hC3);
        expect_write("R6 second", 3'b010, 8'hC3);
        sdi = 1'b0;
        tick();
        check("R6 two strobes", stb_count - n0, 2);
        check("R5 drops after second", int'(wr_stb), 0);
    endtask

    task automatic t_word16();
        sdi = 1'b0;
        tick();  // leading zero of the 16-bit word
        send_frame(3'b100, 3'b100, 8'h17);
        expect_write("R2 16-bit word", 3'b100, 8'h17);
        sdi = 1'b0;
        tick();
    endtask

    task automatic t_mid_reset();
        int n0;
        logic [6:0] part;
        part = 7'b1111011;
        for (int i = 6; i >= 0; i--) begin
            sdi = part[i];
            tick();
        end
        sdi = 1'b0;
        rst = 1'b1;
        tick();
        tick();
        check("R1 mid reset addr", int'(wr_addr), 0);
        check("R1 mid reset data", int'(wr_data), 0);
        rst = 1'b0;
        tick();
        n0 = stb_count;
        send_frame(3'b000, 3'b011, 8'h96);
        expect_write("R1 after mid reset", 3'b011, 8'h96);
        sdi = 1'b0;
        tick();
        check("R1 one strobe after reset", stb_count - n0, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_idle_low();
        t_all_ones();
        t_back_to_back();
        t_word16();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sclk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule